// File: doc/BRIEF.md
# Host Transaction Spacing Gate

This block sits between a USB host scheduler and its packet engine and decides, cycle by cycle, whether the transaction the scheduler is offering may go out now. The scheduler presents a request with a transaction kind and a full-speed tag. The frame timer supplies a start-of-frame strobe. The gate answers with a grant. A grant in a cycle means one transaction is issued in that cycle. The gate never changes a request. It only holds requests back or lets them through.

Three device-compatibility rules are applied as hold-off timers. The first is a 2 µs quiet time after each start-of-frame. The second is a gap of about 12 µs between consecutive full-speed bulk OUT transactions. The third, sparse control scheduling, allows at most one control transaction per microframe. Each rule has its own configuration bit, and all three bits reset to 0. At 125 MHz the quiet time is 250 cycles and the bulk gap is 1500 cycles. Both are derived from parameters.

Two hold-off timers are built from one state machine with states IDLE and HOLD. IDLE goes to HOLD on a start pulse, which loads the counter. HOLD goes back to IDLE when the counter reaches its last cycle, or at once on a cancel pulse. HOLD also reloads on a new start pulse. The control-slot tracker has the states FREE and USED. FREE goes to USED on a control grant, and USED goes back to FREE on a start-of-frame.

Top module: `txn_spacing_gate`

## Requirements
- R1: After reset all hold-offs are clear: with no request the grant is low, and a request of any kind is granted at once, before any start-of-frame has been seen.
- R2: The grant is high only in a cycle where the request is valid and no hold-off applies. It is combinational in that cycle, and each granted cycle counts as one issued transaction.
- R3: No grant is given in a cycle where the start-of-frame strobe is high.
- R4: With the no-wait bit at 0, after a start-of-frame in cycle t no grant is given in cycles t+1 to t+250, and a pending request is granted in cycle t+251.
- R5: With the no-wait bit at 1, a request in the cycle after a start-of-frame is granted, and a start-of-frame in this mode ends any quiet time in progress.
- R6: A start-of-frame during a quiet time restarts the 250-cycle wait from that strobe.
- R7: With the bulk-gap bit at 1, after a grant of a full-speed bulk OUT request (kind 2'b10, full-speed tag 1) in cycle t, no further full-speed bulk OUT is granted before cycle t+1501. A request held pending is granted in cycle t+1501.
- R8: The bulk gap does not hold back any other request: not high-speed bulk OUT, not control (2'b01), not bulk IN (2'b11) and not periodic (2'b00).
- R9: With the bulk-gap bit at 0, full-speed bulk OUT requests are granted back to back.
- R10: With the sparse-control bit at 1, at most one control request is granted between two start-of-frame strobes. A start-of-frame frees the slot again.
- R11: With the sparse-control bit at 0, control requests are granted back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame strobe, one cycle |
| req_valid_i | input | 1 | Scheduler offers a transaction |
| req_kind_i | input | 2 | 00 periodic, 01 control, 10 bulk OUT, 11 bulk IN |
| req_fs_i | input | 1 | 1 when the endpoint is full speed |
| cfg_no_wait_i | input | 1 | 1 skips the post-start-of-frame quiet time |
| cfg_bulk_gap_i | input | 1 | 1 enables the full-speed bulk OUT gap |
| cfg_sparse_ctrl_i | input | 1 | 1 limits control grants to one per microframe |
| grant_o | output | 1 | Transaction may be issued in this cycle |

## Verification
The hardest conditions to reach are those where several hold-offs overlap. One is a start-of-frame that lands inside a running quiet time or bulk gap. Another is a control slot already used when the frame boundary arrives. A third is another kind of request offered while a bulk gap is still counting. The stimulus reaches each of these on purpose: it places strobes partway through running windows and switches the request kind while a gap is open. It then finishes with a long random mix of kinds, speeds, strobes and configuration bits. A behavioural reference model predicts the grant in every cycle.

// File: rtl/txn_gate_pkg.sv
package txn_gate_pkg;

    typedef enum logic [1:0] {
        KIND_PERIODIC = 2'b00,
        KIND_CONTROL  = 2'b01,
        KIND_BULK_OUT = 2'b10,
        KIND_BULK_IN  = 2'b11
    } req_kind_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_HOLD = 1'b1
    } tmr_state_e;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_USED = 1'b1
    } slot_state_e;

endpackage

// File: rtl/hold_timer.sv
module hold_timer
    import txn_gate_pkg::*;
#(
    parameter int CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic hold_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (start_i) begin
            state_d = TMR_HOLD;
            cnt_d   = LOAD_VAL;
        end else if (cancel_i) begin
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    cnt_d = '0;
                end
                TMR_HOLD: begin
                    if (cnt_q == LAST_VAL) begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - LAST_VAL;
                    end
                end
                default: begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            TMR_IDLE: hold_o = 1'b0;
            TMR_HOLD: hold_o = 1'b1;
            default:  hold_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctrl_slot_tracker.sv
module ctrl_slot_tracker
    import txn_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic ctrl_grant_i,
    output logic used_o
);
    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (ctrl_grant_i && !frame_i) state_d = SLOT_USED;
            SLOT_USED: if (frame_i)                  state_d = SLOT_FREE;
            default:                                 state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLOT_FREE: used_o = 1'b0;
            SLOT_USED: used_o = 1'b1;
            default:   used_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/txn_spacing_gate.sv
module txn_spacing_gate
    import txn_gate_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int QUIET_NS    = 2000,
    parameter int BULK_GAP_NS = 12000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof_i,
    input  logic       req_valid_i,
    input  logic [1:0] req_kind_i,
    input  logic       req_fs_i,
    input  logic       cfg_no_wait_i,
    input  logic       cfg_bulk_gap_i,
    input  logic       cfg_sparse_ctrl_i,
    output logic       grant_o
);
    localparam int QUIET_CYC = (CLK_MHZ * QUIET_NS) / 1000;
    localparam int GAP_CYC   = (CLK_MHZ * BULK_GAP_NS) / 1000;

    req_kind_e kind;
    logic      is_ctrl, is_fs_bulk_out;
    logic      quiet_hold, gap_hold, slot_used;
    logic      grant_int;

    assign kind           = req_kind_e'(req_kind_i);
    assign is_ctrl        = (kind == KIND_CONTROL);
    assign is_fs_bulk_out = (kind == KIND_BULK_OUT) && req_fs_i;

    hold_timer #(.CYCLES(QUIET_CYC)) u_quiet (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (sof_i && !cfg_no_wait_i),
        .cancel_i (sof_i &&  cfg_no_wait_i),
        .hold_o   (quiet_hold)
    );

    hold_timer #(.CYCLES(GAP_CYC)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (grant_int && is_fs_bulk_out && cfg_bulk_gap_i),
        .cancel_i (1'b0),
        .hold_o   (gap_hold)
    );

    ctrl_slot_tracker u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_i      (sof_i),
        .ctrl_grant_i (grant_int && is_ctrl),
        .used_o       (slot_used)
    );

    always_comb begin
        grant_int = req_valid_i && !sof_i && !quiet_hold;
        if (is_fs_bulk_out && gap_hold)
            grant_int = 1'b0;
        if (is_ctrl && cfg_sparse_ctrl_i && slot_used)
            grant_int = 1'b0;
    end

    assign grant_o = grant_int;

endmodule

// File: rtl/txn_spacing_gate_chk.sv
module txn_spacing_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sof_i,
    input logic       req_valid_i,
    input logic [1:0] req_kind_i,
    input logic       req_fs_i,
    input logic       cfg_no_wait_i,
    input logic       cfg_bulk_gap_i,
    input logic       cfg_sparse_ctrl_i,
    input logic       grant_o
);
    logic fsbo_grant, ctrl_grant;
    assign fsbo_grant = grant_o && req_kind_i == 2'b10 && req_fs_i;
    assign ctrl_grant = grant_o && req_kind_i == 2'b01;

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> req_valid_i); // R2

    AST_NO_GRANT_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |-> !grant_o); // R3

    AST_QUIET_AFTER_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && !cfg_no_wait_i) |=> !grant_o); // R4

    AST_BULK_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsbo_grant && cfg_bulk_gap_i) |=> !fsbo_grant); // R7

    AST_ONE_CTRL_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_grant |=> !(ctrl_grant && cfg_sparse_ctrl_i)); // R10

endmodule

bind txn_spacing_gate txn_spacing_gate_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .sof_i             (sof_i),
    .req_valid_i       (req_valid_i),
    .req_kind_i        (req_kind_i),
    .req_fs_i          (req_fs_i),
    .cfg_no_wait_i     (cfg_no_wait_i),
    .cfg_bulk_gap_i    (cfg_bulk_gap_i),
    .cfg_sparse_ctrl_i (cfg_sparse_ctrl_i),
    .grant_o           (grant_o)
);

// File: tb/sim_txn_spacing_gate.sv
module sim_txn_spacing_gate;
    localparam int CLK_PERIOD = 8;
    localparam int QUIET      = 250;
    localparam int GAP        = 1500;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sof;
    logic       valid;
    logic [1:0] kind;
    logic       fs;
    logic       no_wait, bulk_gap, sparse;
    logic       grant;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int  m_quiet   = 0;
    int  m_gap     = 0;
    bit  m_used    = 0;
    bit  m_aftsof  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_spacing_gate u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .sof_i             (sof),
        .req_valid_i       (valid),
        .req_kind_i        (kind),
        .req_fs_i          (fs),
        .cfg_no_wait_i     (no_wait),
        .cfg_bulk_gap_i    (bulk_gap),
        .cfg_sparse_ctrl_i (sparse),
        .grant_o           (grant)
    );

    function automatic bit model_grant();
        bit fsbo;
        fsbo = (kind == 2'b10) && fs;
        if (!valid || sof || m_quiet > 0) return 1'b0;
        if (fsbo && m_gap > 0) return 1'b0;
        if (kind == 2'b01 && sparse && m_used) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string reason(bit e);
        bit fsbo;
        fsbo = (kind == 2'b10) && fs;
        if (!valid) return "R2";
        if (sof) return "R3";
        if (m_quiet > 0) return "R4/R6";
        if (fsbo && m_gap > 0) return "R7";
        if (kind == 2'b01 && sparse && m_used) return "R10";
        if (e && m_aftsof) return "R5";
        if (e && m_gap > 0) return "R8";
        if (e && fsbo && !bulk_gap) return "R9";
        if (e && kind == 2'b01 && !sparse) return "R11";
        return "R2";
    endfunction

    // one cycle: inputs already driven at a falling edge
    task automatic tick();
        bit e;
        #1;
        e = model_grant();
        n_tests++;
        if (grant !== e) begin
            n_fail++;
            $display("[TB] FAIL %s t=%0t grant=%b expected=%b", reason(e), $time, grant, e);
        end
        // advance model as the next rising edge will
        if (e && (kind == 2'b10) && fs && bulk_gap) m_gap = GAP;
        else if (m_gap > 0) m_gap--;
        if (sof) begin
            m_quiet  = no_wait ? 0 : QUIET;
            m_used   = 0;
            m_aftsof = 1;
        end else begin
            if (m_quiet > 0) m_quiet--;
            if (e && kind == 2'b01) m_used = 1;
            m_aftsof = 0;
        end
        @(negedge clk);
    endtask

    task automatic drive(bit v, bit [1:0] k, bit f, bit s, int n);
        for (int i = 0; i < n; i++) begin
            valid = v; kind = k; fs = f; sof = (i == 0) ? s : 1'b0;
            tick();
        end
    endtask

    task automatic expect_now(bit e, string tag);
        n_tests++;
        #1;
        if (grant !== e) begin
            n_fail++;
            $display("[TB] FAIL %s grant=%b expected=%b", tag, grant, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("[TB] FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sof = 0; valid = 0; kind = 0; fs = 0;
        no_wait = 0; bulk_gap = 0; sparse = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle output low, then immediate grant with no strobe seen
        expect_now(1'b0, "R1");
        valid = 1; kind = 2'b01; expect_now(1'b1, "R1");
        drive(0, 2'b00, 0, 0, 2);
        drive(1, 2'b11, 1, 0, 2);

        // R3 and R4: strobe with quiet time, request held throughout
        drive(1, 2'b11, 0, 1, QUIET + 10);
        // R6: second strobe partway through the quiet time
        drive(1, 2'b00, 0, 1, 100);
        drive(1, 2'b00, 0, 1, QUIET + 5);

        // R5: no-wait mode, strobe in quiet time cancels it
        drive(0, 2'b00, 0, 1, 20);
        no_wait = 1;
        drive(1, 2'b01, 0, 1, 4);

        // R7: full-speed bulk OUT held across the gap
        bulk_gap = 1;
        drive(1, 2'b10, 1, 0, GAP + 10);
        // R8: other kinds pass while the gap runs
        drive(1, 2'b10, 1, 0, 1);
        drive(1, 2'b10, 0, 0, 3);
        drive(1, 2'b01, 1, 0, 3);
        drive(1, 2'b11, 1, 0, 3);
        drive(1, 2'b00, 1, 0, 3);
        drive(1, 2'b10, 1, 1, 5);
        drive(1, 2'b10, 1, 0, GAP);
        // R9: gap disabled
        bulk_gap = 0;
        drive(0, 2'b00, 0, 0, GAP);
        drive(1, 2'b10, 1, 0, 6);

        // R10: sparse control, one per frame, strobe frees slot
        sparse = 1;
        drive(1, 2'b01, 0, 0, 20);
        drive(1, 2'b01, 0, 1, 20);
        drive(1, 2'b11, 0, 0, 3);
        // R11: sparse off
        sparse = 0;
        drive(1, 2'b01, 0, 0, 6);

        // random mix
        for (int r = 0; r < 6000; r++) begin
            if (r % 500 == 0) begin
                no_wait  = 1'($urandom);
                bulk_gap = 1'($urandom);
                sparse   = 1'($urandom);
            end
            valid = 1'($urandom);
            kind  = 2'($urandom);
            fs    = 1'($urandom);
            sof   = ($urandom % 300) == 0;
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule